// File: doc/BRIEF.md
# Reconfigurable Task Lifecycle Controller

This block is the control machine that sits beside one reconfigurable task. It keeps track of whether the task's hardware is absent, loaded but idle, or running. It has exactly three states: ABSENT, READY and RUN. Activation happens only through a broadcast marker bus. Every task watches the bus, and a task starts only when the marker on the bus equals the identifier fixed into it at build time.

When a running task's local exit condition becomes true, the task stops and returns to READY. It then hands control to its successor. It does this by placing the successor's identifier on its marker-send port and by pulsing a load request, so that the successor can be prefetched. A send that the bus does not acknowledge at once is held until the acknowledge arrives. The own identifier, the successor identifier and the marker width are parameters. The datapath, the loading itself and the bus transport stay outside the block.

Top module: `task_lifecycle_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the machine in ABSENT, with the output enable, processing enable, marker-send valid and load request all low.
- R2: In ABSENT, a high load-done input moves the machine to READY. In READY and RUN, load-done has no effect.
- R3: In READY, when the marker valid strobe is high, the marker data equals the parameter OWN_ID and replace is low, the machine moves to RUN. The output enable and processing enable go high in the next cycle.
- R4: In RUN, an accepted exit condition returns the machine to READY. In the cycle after the edge that accepts it, both enables are low and load request and marker-send valid are high.
- R5: In READY, a high replace input moves the machine to ABSENT, even if a matching marker arrives in the same cycle. In RUN, replace is ignored.
- R6: Marker-send data equals the parameter NEXT_ID while marker-send valid is high, and is all zeros otherwise.
- R7: Load request is high for exactly one cycle per handoff. Marker-send valid stays high until a clock edge samples send-acknowledge high, and drops in the cycle after that edge.
- R8: The machine ignores markers that arrive in ABSENT or in RUN, and it ignores markers whose value is not OWN_ID.
- R9: While a previous marker send is still unacknowledged, the machine defers the exit condition and stays in RUN.
- R10: The output enable and the processing enable are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_done_i | input | 1 | Task hardware has been loaded |
| replaced_i | input | 1 | Task area has been overwritten |
| mk_valid_i | input | 1 | Broadcast marker strobe |
| mk_data_i | input | MARK_W | Broadcast marker value |
| exit_cond_i | input | 1 | Local exit condition of the running task |
| send_ack_i | input | 1 | Bus has taken the outgoing marker |
| out_en_o | output | 1 | Task outputs enabled |
| proc_en_o | output | 1 | Signal processing enabled |
| mk_send_valid_o | output | 1 | Outgoing marker present |
| mk_send_data_o | output | MARK_W | Outgoing marker value |
| load_req_o | output | 1 | Prefetch request for the successor |

## Verification
The bench sweeps every marker value in each of the three states. In ABSENT and RUN this shows that no value has any effect, and in READY it shows that only the one matching value starts the task. The handoff is run three ways: with the acknowledge already high, with it delayed by several cycles, and with a second exit raised while a send is still pending. These runs separate a single-cycle send from a held send and from a deferred exit. Replacement is applied on its own, together with a matching marker, and in RUN, which separates the ABSENT and READY states that the enables alone cannot show.

// File: rtl/tlc_pkg.sv
// Shared types for the task lifecycle controller.
// Assumes: nothing beyond the 1800-2017 enum rules.
package tlc_pkg;
    typedef enum logic [1:0] {
        TS_ABSENT = 2'd0,
        TS_READY  = 2'd1,
        TS_RUN    = 2'd2
    } task_state_t;
endpackage

// File: rtl/tlc_match.sv
// Marker comparator: flags a valid broadcast marker equal to the fixed own id.
// Assumes: ID fits in MARK_W bits; purely combinational.
module tlc_match #(
    parameter int          MARK_W = 8,
    parameter logic [MARK_W-1:0] ID = '0
) (
    input  logic              valid_i,
    input  logic [MARK_W-1:0] data_i,
    output logic              hit_o
);
    logic [MARK_W-1:0] bit_eq;

    // per-bit equality against the hard-wired identifier
    for (genvar b = 0; b < MARK_W; b++) begin : g_bit
        assign bit_eq[b] = ~(data_i[b] ^ ID[b]);
    end

    // hit only on a strobed marker with all bits equal
    always_comb hit_o = valid_i && (&bit_eq);
endmodule

// File: rtl/tlc_fsm.sv
// Three-state lifecycle machine: ABSENT -> READY -> RUN -> READY, READY -> ABSENT.
// Assumes: hit_i is a qualified marker match; busy_i is high while an earlier
// handoff send is still waiting for its acknowledge.
module tlc_fsm
    import tlc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_done_i,
    input  logic        replaced_i,
    input  logic        hit_i,
    input  logic        exit_i,
    input  logic        busy_i,
    output task_state_t st_o,
    output logic        fire_o
);
    task_state_t st_q, st_d;

    // exit accepted only in RUN with no send outstanding
    always_comb fire_o = (st_q == TS_RUN) && exit_i && !busy_i;

    // next-state selection; replace wins over activation in READY
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_ABSENT: if (load_done_i) st_d = TS_READY;
            TS_READY: begin
                if (replaced_i)  st_d = TS_ABSENT;
                else if (hit_i)  st_d = TS_RUN;
            end
            TS_RUN:    if (fire_o) st_d = TS_READY;
            default:   st_d = TS_ABSENT;
        endcase
    end

    // state register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TS_ABSENT;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_ABSENT && load_done_i) |=> (st_q == TS_READY));
    a_r3_activate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_READY && hit_i && !replaced_i) |=> (st_q == TS_RUN));
    a_r5_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_READY && replaced_i) |=> (st_q == TS_ABSENT));
    a_r9_defer: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_RUN && busy_i) |=> (st_q == TS_RUN));
    a_r8_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_RUN && !exit_i) |=> (st_q == TS_RUN));
endmodule

// File: rtl/tlc_handoff.sv
// Handoff generator: on an accepted exit pulses the load request and presents
// the successor id until the bus acknowledges it.
// Assumes: fire_i is never high while busy_o is high (the FSM defers it).
module tlc_handoff #(
    parameter int                MARK_W = 8,
    parameter logic [MARK_W-1:0] NEXT  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              ack_i,
    output logic              send_valid_o,
    output logic [MARK_W-1:0] send_data_o,
    output logic              load_req_o,
    output logic              busy_o
);
    logic pend_q;
    logic req_q;

    // pending send: set by a handoff, cleared by a sampled acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)               pend_q <= 1'b0;
        else if (fire_i)          pend_q <= 1'b1;
        else if (pend_q && ack_i) pend_q <= 1'b0;
    end

    // one-cycle load request per handoff
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= fire_i;
    end

    // drive successor id only while the send is valid
    always_comb send_data_o = pend_q ? NEXT : '0;

    assign send_valid_o = pend_q;
    assign load_req_o   = req_q;
    assign busy_o       = pend_q;

    a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |=> !load_req_o);
    a_r7_send_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (send_valid_o && !ack_i) |=> (send_valid_o && $stable(send_data_o)));
    a_r4_paired: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |-> send_valid_o);
endmodule

// File: rtl/task_lifecycle_ctrl.sv
// Top: per-task lifecycle controller on a broadcast activation-marker bus.
// Assumes: OWN_ID and NEXT_ID fixed at build time; all inputs synchronous to clk.
module task_lifecycle_ctrl #(
    parameter int                MARK_W  = 8,
    parameter logic [MARK_W-1:0] OWN_ID  = 8'h01,
    parameter logic [MARK_W-1:0] NEXT_ID = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_done_i,
    input  logic              replaced_i,
    input  logic              mk_valid_i,
    input  logic [MARK_W-1:0] mk_data_i,
    input  logic              exit_cond_i,
    input  logic              send_ack_i,
    output logic              out_en_o,
    output logic              proc_en_o,
    output logic              mk_send_valid_o,
    output logic [MARK_W-1:0] mk_send_data_o,
    output logic              load_req_o
);
    import tlc_pkg::*;

    logic        hit;
    logic        fire;
    logic        busy;
    task_state_t st;

    tlc_match #(.MARK_W(MARK_W), .ID(OWN_ID)) u_match (
        .valid_i (mk_valid_i),
        .data_i  (mk_data_i),
        .hit_o   (hit)
    );

    tlc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_done_i (load_done_i),
        .replaced_i  (replaced_i),
        .hit_i       (hit),
        .exit_i      (exit_cond_i),
        .busy_i      (busy),
        .st_o        (st),
        .fire_o      (fire)
    );

    tlc_handoff #(.MARK_W(MARK_W), .NEXT(NEXT_ID)) u_handoff (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire_i       (fire),
        .ack_i        (send_ack_i),
        .send_valid_o (mk_send_valid_o),
        .send_data_o  (mk_send_data_o),
        .load_req_o   (load_req_o),
        .busy_o       (busy)
    );

    // both enables follow the RUN state
    always_comb begin
        proc_en_o = (st == TS_RUN);
        out_en_o  = (st == TS_RUN);
    end

    a_r10_enables: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_o == proc_en_o);
    a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proc_en_o) |-> $past(mk_valid_i && mk_data_i == OWN_ID));
endmodule

// File: tb/test_task_lifecycle_ctrl.sv
module test_task_lifecycle_ctrl;
    localparam int         MW   = 4;
    localparam logic [3:0] OWN  = 4'd5;
    localparam logic [3:0] NEXT = 4'd9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_done = 1'b0, replaced = 1'b0, mk_valid = 1'b0;
    logic [3:0] mk_data = '0;
    logic       exit_c = 1'b0, ack = 1'b0;
    logic       out_en, proc_en, sv, lr;
    logic [3:0] sd;
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    task_lifecycle_ctrl #(.MARK_W(MW), .OWN_ID(OWN), .NEXT_ID(NEXT)) i_task_lifecycle_ctrl (
        .clk(clk), .rst_n(rst_n), .load_done_i(load_done), .replaced_i(replaced),
        .mk_valid_i(mk_valid), .mk_data_i(mk_data), .exit_cond_i(exit_c),
        .send_ack_i(ack), .out_en_o(out_en), .proc_en_o(proc_en),
        .mk_send_valid_o(sv), .mk_send_data_o(sd), .load_req_o(lr));

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // packs {out_en, proc_en, sv, lr} for compact compares
    function automatic int outs();
        return {out_en, proc_en, sv, lr};
    endfunction

    task automatic marker(input logic [3:0] v);
        mk_valid = 1'b1; mk_data = v; step(); mk_valid = 1'b0; mk_data = '0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); step();
        chk("R1 reset outputs", outs(), 0);
        chk("R6 idle data", int'(sd), 0);
        rst_n = 1'b1; step();

        // R8: every marker ignored in ABSENT
        for (int v = 0; v < 16; v++) begin
            marker(v[3:0]); chk("R8 absent marker", outs(), 0);
        end
        // R2: load, then sweep the mismatches in READY
        load_done = 1'b1; step(); load_done = 1'b0;
        for (int v = 0; v < 16; v++) begin
            if (v[3:0] != OWN) begin
                marker(v[3:0]); chk("R8 mismatch in ready", outs(), 0);
            end
        end
        marker(OWN);
        chk("R3 activation", outs(), 4'b1100);
        // R8/R5/R2 ignored in RUN
        for (int v = 0; v < 16; v++) begin
            marker(v[3:0]); chk("R8 run marker", outs(), 4'b1100);
        end
        replaced = 1'b1; load_done = 1'b1; step(); replaced = 1'b0; load_done = 1'b0;
        chk("R5 replace ignored in run", outs(), 4'b1100);

        // R4/R7 handoff with delayed acknowledge
        exit_c = 1'b1; step(); exit_c = 1'b0;
        chk("R4 exit outputs", outs(), 4'b0011);
        chk("R6 send data", int'(sd), int'(NEXT));
        step();
        chk("R7 request one cycle, send held", outs(), 4'b0010);
        step();
        chk("R7 send still held", outs(), 4'b0010);
        chk("R6 held data", int'(sd), int'(NEXT));
        ack = 1'b1; step(); ack = 1'b0;
        chk("R7 send released", outs(), 0);
        chk("R6 data cleared", int'(sd), 0);

        // R7 immediate acknowledge gives a one-cycle send
        marker(OWN);
        chk("R3 reactivation", outs(), 4'b1100);
        exit_c = 1'b1; ack = 1'b1; step(); exit_c = 1'b0;
        chk("R4 exit with ack", outs(), 4'b0011);
        step(); ack = 1'b0;
        chk("R7 single-cycle send", outs(), 0);

        // R9 deferred exit while send pending
        marker(OWN);
        exit_c = 1'b1; step(); exit_c = 1'b0;
        chk("R4 exit pending", outs(), 4'b0011);
        marker(OWN);
        chk("R3 active with send pending", outs(), 4'b1110);
        exit_c = 1'b1; step();
        chk("R9 exit deferred", outs(), 4'b1110);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R9 still run at ack", outs(), 4'b1100);
        step(); exit_c = 1'b0;
        chk("R9 deferred exit taken", outs(), 4'b0011);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R7 released", outs(), 0);

        // R5 replace in READY wins over a matching marker
        replaced = 1'b1; mk_valid = 1'b1; mk_data = OWN; step();
        replaced = 1'b0; mk_valid = 1'b0;
        chk("R5 replace beats marker", outs(), 0);
        marker(OWN);
        chk("R5 absent after replace", outs(), 0);
        load_done = 1'b1; step(); load_done = 1'b0;
        marker(OWN);
        chk("R2 reload then activate", outs(), 4'b1100);
        chk("R10 enables equal", int'(out_en), int'(proc_en));

        rst_n = 1'b0; step();
        chk("R1 reset from run", outs(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule